// File: doc/BRIEF.md
# Dual-Channel Converter Serial Output Sequencer

This block reproduces the digital output side of a two-channel simultaneous-sampling converter. A host supplies two sample words, a line-mode select, an active-low conversion-start strobe and a serial clock. The block answers with one or two serial data lines. Each line has its own output-enable, which stands in for the high-impedance state. A frame holds a short run of leading zeros, the sample bits most significant first, and trailing low levels. At the end of the frame the lines are either released or kept driven.

Both strobe and serial clock are sampled by the system clock `clk` and edge-detected, optionally through a synchronizer chain. Bit slots are numbered by the count of serial-clock rising edges seen since the frame began. In two-line mode each channel leaves on its own line. In one-line mode both channels leave back to back on the first line. The point at which the strobe returns high, measured against numbered serial-clock edges, decides whether the lines stay driven for a following conversion or are released so another device can share the lines.

Top module: `dual_adc_serout`

## Requirements
- R1: After reset both output-enables are low and both data outputs are low.
- R2: A falling edge of `start_n` while idle begins a frame. Line A is then enabled and driven low, and line B is enabled only when `dual_sel` is 1 (two-line mode).
- R3: After serial-clock rising edge k of a frame, the data for slot k is shown. Slots 0 to 3 are low. In two-line mode, slot k (4..15) carries bit 15-k of `samp_a` on line A and of `samp_b` on line B, so the MSB comes first.
- R4: In two-line mode a frame is 16 slots long, and line A and line B are low from slot 16 onward.
- R5: In one-line mode (`dual_sel` 0), line A carries 28 slots: slots 0-3 low, slots 4-15 `samp_a` bits 11..0, slot 16 low, and slots 17-28 `samp_b` bits 11..0. Line B stays disabled.
- R6: Both sample words and the mode are captured when a frame begins. Later changes on `samp_a`, `samp_b` or `dual_sel` do not alter that frame.
- R7: In two-line mode, a rising edge of `start_n` seen while the slot count is 14, 15 or 16 and before the 16th serial-clock falling edge keeps the lines driven after the frame. The lines stay low until `start_n` is low again, which starts the next frame.
- R8: In one-line mode, a rising edge of `start_n` seen while the slot count is 14 to 27 keeps the lines driven after the 28th falling edge. After that frame the lines read low from slot 29 onward.
- R9: If no qualifying rise has occurred by the frame's last serial-clock falling edge (16th or 28th), the lines stay enabled until the next rising edge of either `start_n` or the serial clock, and are disabled right after it.
- R10: A rising edge of `start_n` before slot 14, or after slot 16 in two-line mode and after slot 27 in one-line mode, does not keep the lines driven. The frame still ends by R9.
- R11: While a line is enabled, its data changes only after a serial-clock rising edge or at the start of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all host signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n | input | 1 | Conversion-start strobe, active low |
| ser_clk | input | 1 | Serial clock from the host |
| dual_sel | input | 1 | 1 selects two-line mode, 0 selects one-line mode |
| samp_a | input | DATA_W | Channel A sample word |
| samp_b | input | DATA_W | Channel B sample word |
| sdo_a | output | 1 | Serial data line A |
| sdo_a_en | output | 1 | Drive enable of line A (low means high impedance) |
| sdo_b | output | 1 | Serial data line B |
| sdo_b_en | output | 1 | Drive enable of line B (low means high impedance) |

## Verification
The bench targets the edges of the continuation window: a strobe rise just before slot 14, at slot 14, at slot 16 in two-line mode, and at slots 27 and 28 in one-line mode. A design with an off-by-one window would hold the lines when it should release them, or release them when it should hold. It releases frames both by a strobe rise and by a serial-clock rise. A design that waited for only one of these would stay enabled and block the shared lines. It scrambles the sample inputs just after each frame starts, so a design that forgot to capture the words would shift out the wrong bits. It also checks the slot after the MSB and the gap slot in one-line mode, which catches a data path that is one slot early or late.

// File: rtl/dso_pkg.sv
package dso_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FRAME   = 2'd1,
      ST_HOLD    = 2'd2,
      ST_RELEASE = 2'd3
   } dso_state_e;

   localparam int LINES = 2;

endpackage

// File: rtl/dso_edge.sv
module dso_edge #(
   parameter int   SYNC_STAGES = 0,
   parameter logic RESET_VAL   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);

   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {SYNC_STAGES{RESET_VAL}};
            else        chain_q <= {chain_q[SYNC_STAGES-2+((SYNC_STAGES==1)?1:0):0], din};
         end
         assign level = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RESET_VAL;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;

endmodule

// File: rtl/dso_slot_mux.sv
module dso_slot_mux #(
   parameter int DATA_W = 12,
   parameter int LEAD   = 3,
   parameter int GAP    = 1,
   parameter int CNT_W  = 5
) (
   input  logic [CNT_W-1:0]  slot,
   input  logic              dual,
   input  logic [DATA_W-1:0] word_a,
   input  logic [DATA_W-1:0] word_b,
   output logic              bit_a,
   output logic              bit_b
);

   localparam int IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam int A_FIRST  = LEAD + 1;
   localparam int A_LAST   = LEAD + DATA_W;
   localparam int B_FIRST  = A_LAST + GAP + 1;
   localparam int B_LAST   = A_LAST + GAP + DATA_W;

   always_comb begin
      int k;
      k     = int'(slot);
      bit_a = 1'b0;
      bit_b = 1'b0;
      if (k >= A_FIRST && k <= A_LAST) begin
         bit_a = word_a[IDX_W'(A_LAST - k)];
         if (dual) bit_b = word_b[IDX_W'(A_LAST - k)];
      end else if (!dual && k >= B_FIRST && k <= B_LAST) begin
         bit_a = word_b[IDX_W'(B_LAST - k)];
      end
   end

endmodule

// File: rtl/dso_seq.sv
module dso_seq
   import dso_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int LEAD      = 3,
   parameter int GAP       = 1,
   parameter int WIN_START = 14,
   parameter int CNT_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_lvl,
   input  logic              strobe_rise,
   input  logic              strobe_fall,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              dual_in,
   input  logic [DATA_W-1:0] word_a_in,
   input  logic [DATA_W-1:0] word_b_in,
   output dso_state_e        state,
   output logic [CNT_W-1:0]  slot,
   output logic              dual_q,
   output logic [DATA_W-1:0] word_a_q,
   output logic [DATA_W-1:0] word_b_q,
   output logic              start
);

   localparam int DUAL_LEN   = LEAD + DATA_W + 1;
   localparam int SINGLE_LEN = LEAD + 2 * DATA_W + GAP;
   localparam logic [CNT_W-1:0] C_DUAL     = CNT_W'(DUAL_LEN);
   localparam logic [CNT_W-1:0] C_SINGLE   = CNT_W'(SINGLE_LEN);
   localparam logic [CNT_W-1:0] C_SINGLE_W = CNT_W'(SINGLE_LEN - 1);
   localparam logic [CNT_W-1:0] C_WIN_LO   = CNT_W'(WIN_START);
   localparam logic [CNT_W-1:0] C_MAX      = {CNT_W{1'b1}};

   logic             keep_q;
   logic             in_window;
   logic             keep_now;
   logic [CNT_W-1:0] frame_len;
   logic [CNT_W-1:0] win_hi;
   logic [CNT_W-1:0] slot_inc;

   assign frame_len = dual_q ? C_DUAL : C_SINGLE;
   assign win_hi    = dual_q ? C_DUAL : C_SINGLE_W;
   assign in_window = (slot >= C_WIN_LO) && (slot <= win_hi);
   assign keep_now  = keep_q | (strobe_rise & in_window);
   assign slot_inc  = (sck_rise && slot != C_MAX) ? slot + 1'b1 : slot;

   assign start = ((state == ST_IDLE) && strobe_fall) ||
                  ((state == ST_HOLD) && !strobe_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         slot     <= '0;
         keep_q   <= 1'b0;
         dual_q   <= 1'b0;
         word_a_q <= '0;
         word_b_q <= '0;
      end else if (start) begin
         state    <= ST_FRAME;
         slot     <= '0;
         keep_q   <= 1'b0;
         dual_q   <= dual_in;
         word_a_q <= word_a_in;
         word_b_q <= word_b_in;
      end else begin
         case (state)
            ST_FRAME: begin
               slot   <= slot_inc;
               keep_q <= keep_now;
               if (sck_fall && slot >= frame_len)
                  state <= keep_now ? ST_HOLD : ST_RELEASE;
            end
            ST_HOLD: slot <= slot_inc;
            ST_RELEASE: begin
               slot <= slot_inc;
               if (sck_rise || strobe_rise) state <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   // R9: a pending release waits for a strobe or clock rise
   p_release_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RELEASE && !sck_rise && !strobe_rise && !start) |=> state == ST_RELEASE);

   // R10: a strobe rise below the window never marks continuation
   p_early_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FRAME && !keep_q && strobe_rise && slot < C_WIN_LO && !sck_fall) |=> !keep_q);

   // R9: frame end without a qualifying rise goes to release
   p_end_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FRAME && sck_fall && slot >= frame_len && !keep_q && !strobe_rise)
      |=> state == ST_RELEASE);

   // R6: captured words do not move during a frame
   p_words_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FRAME && !start) |=> ($stable(word_a_q) && $stable(word_b_q) && $stable(dual_q)));

endmodule

// File: rtl/dual_adc_serout.sv
module dual_adc_serout
   import dso_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int LEAD        = 3,
   parameter int GAP         = 1,
   parameter int WIN_START   = 14,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_n,
   input  logic              ser_clk,
   input  logic              dual_sel,
   input  logic [DATA_W-1:0] samp_a,
   input  logic [DATA_W-1:0] samp_b,
   output logic              sdo_a,
   output logic              sdo_a_en,
   output logic              sdo_b,
   output logic              sdo_b_en
);

   localparam int SINGLE_LEN = LEAD + 2 * DATA_W + GAP;
   localparam int DUAL_LEN   = LEAD + DATA_W + 1;
   localparam int CNT_W      = $clog2(SINGLE_LEN + 2);

   generate
      if (DATA_W < 2)             begin : g_bad_w    $error("DATA_W must be at least 2"); end
      if (WIN_START <= LEAD)      begin : g_bad_win  $error("WIN_START must follow the lead zeros"); end
      if (WIN_START >= DUAL_LEN)  begin : g_bad_win2 $error("WIN_START must precede frame end"); end
      if (SYNC_STAGES > 4)        begin : g_bad_sync $error("SYNC_STAGES limited to 4"); end
   endgenerate

   logic             st_lvl, st_rise, st_fall;
   logic             ck_lvl, ck_rise, ck_fall;
   dso_state_e       state;
   logic [CNT_W-1:0] slot;
   logic             dual_q, start;
   logic [DATA_W-1:0] word_a_q, word_b_q;
   logic [LINES-1:0] raw_bit, line_en, line_out;

   dso_edge #(.SYNC_STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_strobe (
      .clk(clk), .rst_n(rst_n), .din(start_n),
      .level(st_lvl), .rise(st_rise), .fall(st_fall));

   dso_edge #(.SYNC_STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sck (
      .clk(clk), .rst_n(rst_n), .din(ser_clk),
      .level(ck_lvl), .rise(ck_rise), .fall(ck_fall));

   dso_seq #(
      .DATA_W(DATA_W), .LEAD(LEAD), .GAP(GAP),
      .WIN_START(WIN_START), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .strobe_lvl(st_lvl), .strobe_rise(st_rise), .strobe_fall(st_fall),
      .sck_rise(ck_rise), .sck_fall(ck_fall),
      .dual_in(dual_sel), .word_a_in(samp_a), .word_b_in(samp_b),
      .state(state), .slot(slot), .dual_q(dual_q),
      .word_a_q(word_a_q), .word_b_q(word_b_q), .start(start));

   dso_slot_mux #(
      .DATA_W(DATA_W), .LEAD(LEAD), .GAP(GAP), .CNT_W(CNT_W)
   ) u_mux (
      .slot(slot), .dual(dual_q), .word_a(word_a_q), .word_b(word_b_q),
      .bit_a(raw_bit[0]), .bit_b(raw_bit[1]));

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         if (i == 0) begin : g_primary
            assign line_en[i] = (state != ST_IDLE);
         end else begin : g_secondary
            assign line_en[i] = (state != ST_IDLE) && dual_q;
         end
         assign line_out[i] = line_en[i] & raw_bit[i];
      end
   endgenerate

   assign sdo_a    = line_out[0];
   assign sdo_a_en = line_en[0];
   assign sdo_b    = line_out[1];
   assign sdo_b_en = line_en[1];

   // R5: line B is never enabled without line A
   p_b_needs_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sdo_b_en |-> sdo_a_en);

   // R3: lead slots are low on both lines
   p_lead_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_a_en && slot <= CNT_W'(LEAD)) |-> (!sdo_a && !sdo_b));

   // R11: enabled data moves only after a clock rise or at frame start
   p_data_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_a_en && !ck_rise && !start) |=> ($stable(sdo_a) || !sdo_a_en));

   // R1: lines disabled in idle
   p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (!sdo_a_en && !sdo_b_en && !sdo_a && !sdo_b));

endmodule

// File: tb/sim_dual_adc_serout.sv
module sim_dual_adc_serout;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_n = 1'b1;
   logic          ser_clk = 1'b0;
   logic          dual_sel = 1'b1;
   logic [W-1:0]  samp_a = '0;
   logic [W-1:0]  samp_b = '0;
   logic          sdo_a, sdo_a_en, sdo_b, sdo_b_en;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_adc_serout u0 (
      .clk(clk), .rst_n(rst_n), .start_n(start_n), .ser_clk(ser_clk),
      .dual_sel(dual_sel), .samp_a(samp_a), .samp_b(samp_b),
      .sdo_a(sdo_a), .sdo_a_en(sdo_a_en), .sdo_b(sdo_b), .sdo_b_en(sdo_b_en));

   task automatic chk(input string tag, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   function automatic logic exp_a(input logic dual, input int k,
                                  input logic [W-1:0] a, input logic [W-1:0] b);
      if (k >= 4 && k <= 15) return a[15-k];
      if (!dual && k >= 17 && k <= 28) return b[28-k];
      return 1'b0;
   endfunction

   function automatic logic exp_b(input logic dual, input int k, input logic [W-1:0] b);
      if (dual && k >= 4 && k <= 15) return b[15-k];
      return 1'b0;
   endfunction

   // rise_at: slot after which start_n returns high (0 = held low)
   // by_strobe: release by start_n rise when still low
   task automatic frame(input logic dual, input logic [W-1:0] a, input logic [W-1:0] b,
                        input int rise_at, input bit by_strobe);
      int  len;
      bit  cont;
      len  = dual ? 16 : 28;
      cont = (rise_at != 0) && rise_at >= 14 && rise_at <= (dual ? 16 : 27);
      dual_sel = dual; samp_a = a; samp_b = b;
      start_n = 1'b0;
      step();
      chk("R2 a_en", sdo_a_en, 1'b1);
      chk("R2 b_en", sdo_b_en, dual);
      chk("R2 a low", sdo_a, 1'b0);
      samp_a = W'($urandom); samp_b = W'($urandom); dual_sel = ~dual;  // R6 scramble
      for (int k = 1; k <= len; k++) begin
         ser_clk = 1'b1;
         step();
         chk(dual ? "R3/R4/R6 line a" : "R5/R6 line a", sdo_a, exp_a(dual, k, a, b));
         chk(dual ? "R3/R4 line b" : "R5 line b", sdo_b, exp_b(dual, k, b));
         chk(dual ? "R3 b_en" : "R5 b_en", sdo_b_en, dual);
         if (k == rise_at) begin
            start_n = 1'b1;
            step();
            chk("R11 hold on strobe", sdo_a, exp_a(dual, k, a, b));
         end
         ser_clk = 1'b0;
         step();
         chk("R11 hold on fall", sdo_a, exp_a(dual, k, a, b));
      end
      chk("R9 still driven at end", sdo_a_en, 1'b1);
      if (cont) begin
         ser_clk = 1'b1;
         step();
         chk(dual ? "R7 kept" : "R8 kept", sdo_a_en, 1'b1);
         chk(dual ? "R7 low" : "R8 low", sdo_a, 1'b0);
         chk(dual ? "R7 b kept" : "R8 b off", sdo_b_en, dual);
         ser_clk = 1'b0;
         step();
         chk(dual ? "R7 kept after fall" : "R8 kept after fall", sdo_a_en, 1'b1);
      end else begin
         step();
         chk("R9 waits", sdo_a_en, 1'b1);
         if (start_n == 1'b0 && by_strobe) begin
            start_n = 1'b1;
            step();
            chk("R9 strobe release a", sdo_a_en, 1'b0);
            chk("R9 strobe release b", sdo_b_en, 1'b0);
         end else begin
            ser_clk = 1'b1;
            step();
            chk(rise_at != 0 ? "R10 clock release a" : "R9 clock release a", sdo_a_en, 1'b0);
            chk("R9 clock release b", sdo_b_en, 1'b0);
            ser_clk = 1'b0;
            step();
         end
         chk("R9 line low", sdo_a, 1'b0);
         start_n = 1'b1;
         step();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog: got hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1a2b3c4d));
      repeat (3) step();
      chk("R1 a_en", sdo_a_en, 1'b0);
      chk("R1 b_en", sdo_b_en, 1'b0);
      chk("R1 a", sdo_a, 1'b0);
      rst_n = 1'b1;
      step();
      chk("R1 after release", sdo_a_en, 1'b0);

      frame(1'b1, 12'hA5C, 12'h3F1, 14, 1'b0);   // R7 window low end
      frame(1'b1, 12'h801, 12'h7FE, 16, 1'b0);   // R7 window high end
      frame(1'b1, 12'hFFF, 12'h000, 13, 1'b0);   // R10 too early
      frame(1'b1, 12'h123, 12'hEDC, 0, 1'b1);    // R9 strobe release
      frame(1'b0, 12'hC3A, 12'h5A7, 27, 1'b0);   // R8 window high end
      frame(1'b0, 12'h9E1, 12'h1E9, 28, 1'b0);   // R10 too late
      frame(1'b0, 12'h001, 12'h800, 14, 1'b0);   // R8 window low end
      frame(1'b0, 12'h6B2, 12'hD4D, 0, 1'b0);    // R9 clock release
      frame(1'b0, 12'h777, 12'h888, 0, 1'b1);    // R9 strobe release, one-line

      for (int i = 0; i < 40; i++) begin
         logic dual;
         int   r;
         dual = logic'($urandom & 1);
         r    = ($urandom % 4 == 0) ? 0 : int'($urandom % (dual ? 17 : 29));
         frame(dual, W'($urandom), W'($urandom), r, bit'($urandom & 1));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule